// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

A purely combinational datapath stage that takes two operands of parameterised width, a carry input and a 4-bit function code, and returns one result word together with carry-out and signed overflow. The two high bits of the function code pick the source of the result: the adder path, the bitwise logic path, a one-place right shift or a one-place left shift. The two low bits refine the choice within the adder and logic paths.

The adder path forms A + Y + carry, where every bit of Y is taken from B, the inverse of B, a constant 0 or a constant 1. With the carry input this gives add, add with carry, subtract with borrow, subtract, pass-through of A, increment and decrement. The shift paths draw the bit that enters at the vacant end from a dedicated serial input for each direction. A register file or accumulator around the unit supplies the operands and captures the result.

Top module: `arith_logic_shift_unit`

## Requirements
- R1: With function code 4'b0000, {carry_o, res_o} equals A + B + carry_i as an unsigned sum one bit wider than the operands.
- R2: With function code 4'b0001, {carry_o, res_o} equals A + (bitwise inverse of B) + carry_i, so carry_i = 1 gives A − B and carry_i = 0 gives A − B − 1.
- R3: With function code 4'b0010, {carry_o, res_o} equals A + carry_i (pass A through, or increment).
- R4: With function code 4'b0011, {carry_o, res_o} equals A + (all ones) + carry_i (decrement when carry_i = 0, pass A with carry_o = 1 when carry_i = 1).
- R5: For function codes 4'b00xx, ovf_o is 1 exactly when A and Y have the same sign bit and the result's sign bit differs from it.
- R6: For function codes 4'b01xx the result is A XOR B (low bits 00), A OR B (01), A AND B (10), or the bitwise inverse of A (11).
- R7: For function codes 4'b10xx the result is A shifted right one place, with sr_in_i entering the most significant bit.
- R8: For function codes 4'b11xx the result is A shifted left one place, with sl_in_i entering bit 0.
- R9: For every function code with a nonzero high pair, carry_o and ovf_o are 0 and carry_i has no effect on the result; the low pair has no effect on the shift results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| carry_i | input | 1 | Carry into the adder |
| fn_i | input | 4 | Function code: [3:2] result source, [1:0] sub-operation |
| sr_in_i | input | 1 | Bit entering the top on a right shift |
| sl_in_i | input | 1 | Bit entering bit 0 on a left shift |
| res_o | output | W | Result word |
| carry_o | output | 1 | Carry out of the top adder stage, 0 outside the adder path |
| ovf_o | output | 1 | Signed overflow, 0 outside the adder path |

## Verification
The hardest situation to reach is signed overflow on the subtract and decrement codes, where Y is an inverted or constant word and the carry into the top stage must differ from the carry out of it; only a few operand pairs do this. The bench reaches it by sweeping every operand pair, carry input, function code and both serial inputs on a 4-bit instance, so each overflow boundary (such as 8 − 1 and 7 + 1) is met under every code.

// File: rtl/arith_logic_shift_unit.sv
module arith_logic_shift_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic [3:0]   fn_i,
  input  logic         sr_in_i,
  input  logic         sl_in_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W:0]   c;
  logic [W-1:0] y, sum, lg, shr, shl;
  logic         arith;

  assign c[0]  = carry_i;
  assign arith = (fn_i[3:2] == 2'b00);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i]   = fn_i[1] ? fn_i[0] : (b_i[i] ^ fn_i[0]);
    assign sum[i] = a_i[i] ^ y[i] ^ c[i];
    assign c[i+1] = (a_i[i] & y[i]) | (c[i] & (a_i[i] ^ y[i]));
    assign lg[i]  = fn_i[1] ? (fn_i[0] ? ~a_i[i] : (a_i[i] & b_i[i]))
                            : (fn_i[0] ? (a_i[i] | b_i[i]) : (a_i[i] ^ b_i[i]));
    if (i == W-1) begin : g_top
      assign shr[i] = sr_in_i;
    end else begin : g_mid_r
      assign shr[i] = a_i[i+1];
    end
    if (i == 0) begin : g_bot
      assign shl[i] = sl_in_i;
    end else begin : g_mid_l
      assign shl[i] = a_i[i-1];
    end
    always_comb begin
      case (fn_i[3:2])
        2'b00:   res_o[i] = sum[i];
        2'b01:   res_o[i] = lg[i];
        2'b10:   res_o[i] = shr[i];
        default: res_o[i] = shl[i];
      endcase
    end
  end

  assign carry_o = arith & c[W];
  assign ovf_o   = arith & (c[W] ^ c[W-1]);
endmodule

module arith_logic_shift_unit_props #(
  parameter int W = 8
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         carry_i,
  input logic [3:0]   fn_i,
  input logic         sr_in_i,
  input logic         sl_in_i,
  input logic [W-1:0] res_o,
  input logic         carry_o,
  input logic         ovf_o
);
  logic [W:0] wide;
  logic [W-1:0] yv;
  always_comb begin
    yv   = (fn_i[1:0] == 2'b00) ? b_i : (fn_i[1:0] == 2'b01) ? ~b_i :
           (fn_i[1:0] == 2'b10) ? '0 : '1;
    wide = {1'b0, a_i} + {1'b0, yv} + {{W{1'b0}}, carry_i};
    if (fn_i[3:2] == 2'b00) begin
      a_r1_r4_sum: assert ({carry_o, res_o} == wide)
        else $error("R1-R4 adder mismatch");
      a_r5_overflow: assert (ovf_o == ((a_i[W-1] == yv[W-1]) && (res_o[W-1] != a_i[W-1])))
        else $error("R5 overflow mismatch");
    end else begin
      a_r9_no_flags: assert (!carry_o && !ovf_o)
        else $error("R9 flags set outside adder path");
    end
    if (fn_i == 4'b0111) begin
      a_r6_invert: assert (res_o == ~a_i) else $error("R6 inverse mismatch");
    end
    if (fn_i[3:2] == 2'b10) begin
      a_r7_shift_right: assert (res_o == {sr_in_i, a_i} >> 1)
        else $error("R7 right shift mismatch");
    end
    if (fn_i[3:2] == 2'b11) begin
      a_r8_shift_left: assert (res_o == {a_i[W-2:0], sl_in_i})
        else $error("R8 left shift mismatch");
    end
  end
endmodule

bind arith_logic_shift_unit arith_logic_shift_unit_props #(.W(W)) u_props (
  .a_i(a_i), .b_i(b_i), .carry_i(carry_i), .fn_i(fn_i),
  .sr_in_i(sr_in_i), .sl_in_i(sl_in_i),
  .res_o(res_o), .carry_o(carry_o), .ovf_o(ovf_o)
);

// File: tb/sim_arith_logic_shift_unit.sv
`timescale 1ns/1ps
module sim_arith_logic_shift_unit;
  localparam int W = 4;
  logic clk = 0, rst = 1;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic cin, sr, sl, co, ov;
  logic [3:0] fn;
  int checks = 0, errors = 0;
  bit done = 0;

  arith_logic_shift_unit #(.W(W)) u0 (
    .a_i(a), .b_i(b), .carry_i(cin), .fn_i(fn), .sr_in_i(sr), .sl_in_i(sl),
    .res_o(res), .carry_o(co), .ovf_o(ov)
  );

  task automatic check(string tag, logic [W+1:0] got, logic [W+1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b fn=%b : got {c,v,res}=%h expected %h",
               tag, a, b, cin, fn, got, exp);
    end
  endtask

  initial begin
    a = 0; b = 0; cin = 0; fn = 0; sr = 0; sl = 0;
    repeat (2) @(posedge clk);
    rst = 0;
    @(negedge clk); #2;
    check("R1 idle zero", {co, ov, res}, '0);
    for (int f = 0; f < 16; f++)
      for (int ia = 0; ia < 16; ia++)
        for (int ib = 0; ib < 16; ib++)
          for (int k = 0; k < 8; k++) begin
            logic [W-1:0] y, er;
            logic [W:0] s;
            logic ec, ev;
            string tag;
            @(negedge clk);
            fn = 4'(f); a = 4'(ia); b = 4'(ib);
            cin = k[0]; sr = k[1]; sl = k[2];
            ec = 0; ev = 0;
            case (fn[3:2])
              2'b00: begin
                case (fn[1:0])
                  2'b00: begin y = b;    tag = "R1 add"; end
                  2'b01: begin y = ~b;   tag = "R2 subtract"; end
                  2'b10: begin y = 4'h0; tag = "R3 pass/increment"; end
                  default: begin y = 4'hF; tag = "R4 decrement"; end
                endcase
                s  = 5'(a) + 5'(y) + 5'(cin);
                er = s[W-1:0]; ec = s[W];
                ev = (a[W-1] == y[W-1]) && (er[W-1] != a[W-1]);
              end
              2'b01: begin
                tag = "R6 logic / R9 flags";
                case (fn[1:0])
                  2'b00: er = a ^ b;
                  2'b01: er = a | b;
                  2'b10: er = a & b;
                  default: er = ~a;
                endcase
              end
              2'b10: begin tag = "R7 shift right / R9"; er = {sr, a[W-1:1]}; end
              default: begin tag = "R8 shift left / R9"; er = {a[W-2:0], sl}; end
            endcase
            #2;
            check(tag, {co, ov, res}, {ec, ev, er});
            if (fn[3:2] == 2'b00)
              check("R5 overflow", {2'b0, 3'b0, ov}, {2'b0, 3'b0, ev});
          end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule